// File: doc/BRIEF.md
# Dual-Lane Saturating Negate Unit

This unit takes one packed word that holds two signed lanes and negates each lane on its own. The most negative lane value has no positive counterpart. It is clamped to the largest positive value rather than wrapping back to itself. Each operation also updates a 32-bit arithmetic status word that the block holds internally. The update covers zero, sign, per-lane carry, overflow and sticky overflow. Every other bit of the status word keeps its value.

Operands arrive on a valid/ready input stream and results leave on a valid/ready output stream, through a single register stage. An operand is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output is stalled:
- `out_data` and `status` hold their values.
- No new operand is taken.
- The status word does not move.

The status word is a plain output that always shows the state after the last accepted operand.

Top module: `negsat_dual`

## Requirements
- R1: Each lane of `in_data` is negated independently in two's complement; with the default 16-bit lanes, 0x1234CDEF produces 0xEDCC3211.
- R2: A lane holding the most negative value (0x8000 for 16-bit lanes) produces the most positive value (0x7FFF) instead of wrapping; 0x80008000 produces 0x7FFF7FFF.
- R3: If either lane saturates, status bit 24 (overflow) and bit 3 (its mirror) are set, and bit 25 (sticky overflow) is set; bit 24 set implies bit 25 set.
- R4: If neither lane saturates, bits 24 and 3 are cleared and bit 25 keeps its previous value.
- R5: Status bit 13 (upper-lane carry) is set when the upper input lane is zero and cleared otherwise.
- R6: Status bit 12 (lower-lane carry) and bit 2 (its mirror) are set when the lower input lane is zero and cleared otherwise.
- R7: Status bit 0 (zero) is set when either result lane is zero; bit 1 (negative) is set when either result lane has its top bit set; both are cleared otherwise.
- R8: Status bits other than 0, 1, 2, 3, 12, 13, 24 and 25 are never altered by an operation; from reset they therefore stay zero.
- R9: Asynchronous active-low reset clears the status word to zero and `out_valid` to low.
- R10: An accepted operand shows its result on `out_data`, its updated status on `status`, and `out_valid` high after the same clock edge; the status word changes only on an edge that accepts an operand.
- R11: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high; during a stall `out_data`, `status` and `out_valid` hold and an offered operand is not taken until the stall ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand on `in_data` is offered |
| in_ready | output | 1 | Unit can accept an operand this cycle |
| in_data | input | 2*LANE_W | Packed operand, upper lane in the top half |
| out_valid | output | 1 | `out_data` holds a result not yet taken |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 2*LANE_W | Packed negated result |
| status | output | 32 | Arithmetic status word after the last accepted operand |

## Verification
The bench builds the unit with the default 16-bit lanes, so the exact boundary words can be applied directly and compared bit for bit: 0x1234CDEF, lane values 0x8000 and 0x0000 in each position, and both lanes saturated together. With that width, the sticky overflow bit can be followed through a saturating operation and then a plain one. The output-stall path is also exercised: an operand is held at the input while `out_ready` is low, and the bench confirms it is taken only once the stall ends.

// File: rtl/negsat_pkg.sv
package negsat_pkg;

  localparam int STAT_W = 32;

  // status bit positions
  localparam int FLG_ZERO       = 0;
  localparam int FLG_NEG        = 1;
  localparam int FLG_CLO_MIRROR = 2;
  localparam int FLG_OVF_MIRROR = 3;
  localparam int FLG_CARRY_LO   = 12;
  localparam int FLG_CARRY_HI   = 13;
  localparam int FLG_OVF        = 24;
  localparam int FLG_OVF_STICKY = 25;

  localparam logic [STAT_W-1:0] WRITE_MASK =
      (STAT_W'(1) << FLG_ZERO)     | (STAT_W'(1) << FLG_NEG) |
      (STAT_W'(1) << FLG_CLO_MIRROR) | (STAT_W'(1) << FLG_OVF_MIRROR) |
      (STAT_W'(1) << FLG_CARRY_LO) | (STAT_W'(1) << FLG_CARRY_HI) |
      (STAT_W'(1) << FLG_OVF)      | (STAT_W'(1) << FLG_OVF_STICKY);

  typedef struct packed {
    logic sat;       // lane clamped
    logic src_zero;  // input lane was zero
    logic res_zero;  // result lane is zero
    logic res_neg;   // result lane top bit set
  } lane_flags_t;

endpackage

// File: rtl/negsat_lane.sv
module negsat_lane
  import negsat_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] lane_in,
  output logic [W-1:0] lane_out,
  output lane_flags_t  flags
);

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MOST_POS = ~MOST_NEG;

  logic [W-1:0] negated;
  logic         clamp;

  always_comb begin
    negated  = (~lane_in) + W'(1);
    clamp    = (lane_in == MOST_NEG);
    lane_out = clamp ? MOST_POS : negated;
  end

  always_comb begin
    flags.sat      = clamp;
    flags.src_zero = (lane_in == '0);
    flags.res_zero = (lane_out == '0);
    flags.res_neg  = lane_out[W-1];
  end

endmodule

// File: rtl/negsat_status.sv
module negsat_status
  import negsat_pkg::*;
(
  input  logic [STAT_W-1:0] cur,
  input  lane_flags_t       hi,
  input  lane_flags_t       lo,
  output logic [STAT_W-1:0] nxt
);

  logic any_sat;

  always_comb begin
    any_sat = hi.sat | lo.sat;
    nxt = cur;
    nxt[FLG_ZERO]       = hi.res_zero | lo.res_zero;
    nxt[FLG_NEG]        = hi.res_neg  | lo.res_neg;
    nxt[FLG_CARRY_HI]   = hi.src_zero;
    nxt[FLG_CARRY_LO]   = lo.src_zero;
    nxt[FLG_CLO_MIRROR] = lo.src_zero;
    nxt[FLG_OVF]        = any_sat;
    nxt[FLG_OVF_MIRROR] = any_sat;
    nxt[FLG_OVF_STICKY] = cur[FLG_OVF_STICKY] | any_sat;
  end

endmodule

// File: rtl/negsat_dual.sv
module negsat_dual
  import negsat_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [2*LANE_W-1:0]   in_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [2*LANE_W-1:0]   out_data,
  output logic [STAT_W-1:0]     status
);

  localparam int NLANES = 2;
  localparam int DATA_W = NLANES * LANE_W;

  logic [LANE_W-1:0] lane_res [NLANES];
  lane_flags_t       lane_flg [NLANES];
  logic [DATA_W-1:0] res_word;
  logic [STAT_W-1:0] stat_nxt;
  logic              accept;

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    negsat_lane #(.W(LANE_W)) u_lane (
      .lane_in  (in_data[l*LANE_W +: LANE_W]),
      .lane_out (lane_res[l]),
      .flags    (lane_flg[l])
    );
    assign res_word[l*LANE_W +: LANE_W] = lane_res[l];
  end

  negsat_status u_stat (
    .cur (status),
    .hi  (lane_flg[1]),
    .lo  (lane_flg[0]),
    .nxt (stat_nxt)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      status    <= '0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_data  <= res_word;
        status    <= stat_nxt;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/negsat_dual_chk.sv
module negsat_dual_chk
  import negsat_pkg::*;
#(
  parameter int LANE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [2*LANE_W-1:0] out_data,
  input logic [STAT_W-1:0]   status
);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(status))); // R11

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R11

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R10

  AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(status)); // R10

  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    status[FLG_OVF_STICKY] |=> status[FLG_OVF_STICKY]); // R4

  AST_OVF_IMPLIES_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status[FLG_OVF] |-> status[FLG_OVF_STICKY]); // R3

  AST_OVF_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    status[FLG_OVF] == status[FLG_OVF_MIRROR]); // R3

  AST_CARRY_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    status[FLG_CARRY_LO] == status[FLG_CLO_MIRROR]); // R6

  AST_UNTOUCHED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~WRITE_MASK) == '0); // R8

endmodule

bind negsat_dual negsat_dual_chk #(.LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .status    (status)
);

// File: tb/sim_negsat_dual.sv
module sim_negsat_dual;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic [31:0] status;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] exp_stat = '0;

  always #2 clk = ~clk;

  negsat_dual #(.LANE_W(16)) u0 (
    .clk, .rst_n, .in_valid, .in_ready, .in_data,
    .out_valid, .out_ready, .out_data, .status
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] neg_lane(input logic [15:0] x);
    return (x == 16'h8000) ? 16'h7FFF : 16'h0000 - x;
  endfunction

  function automatic logic [31:0] model_res(input logic [31:0] d);
    return {neg_lane(d[31:16]), neg_lane(d[15:0])};
  endfunction

  function automatic logic [31:0] model_stat(input logic [31:0] cur, input logic [31:0] d);
    logic [31:0] r, s;
    logic sat;
    r = model_res(d);
    sat = (d[31:16] == 16'h8000) || (d[15:0] == 16'h8000);
    s = cur;
    s[0]  = (r[31:16] == 0) || (r[15:0] == 0);
    s[1]  = r[31] || r[15];
    s[13] = (d[31:16] == 0);
    s[12] = (d[15:0] == 0);
    s[2]  = (d[15:0] == 0);
    s[24] = sat;
    s[3]  = sat;
    s[25] = cur[25] | sat;
    return s;
  endfunction

  task automatic apply(input string req, input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    exp_stat = model_stat(exp_stat, d);
    chk({req, " valid"}, {31'b0, out_valid}, 32'd1);
    chk({req, " data"}, out_data, model_res(d));
    chk({req, " status"}, status, exp_stat);
  endtask

  task automatic t_reset;
    chk("R9 status", status, 32'h0);
    chk("R9 out_valid", {31'b0, out_valid}, 32'd0);
    chk("R11 ready idle", {31'b0, in_ready}, 32'd1);
  endtask

  task automatic t_plain;
    apply("R1", 32'h1234CDEF);
    chk("R1 fixed", out_data, 32'hEDCC3211);
    chk("R7 neg only", status & 32'h0300_300F, 32'h0000_0002);
  endtask

  task automatic t_hi_min;
    apply("R2", 32'h8000_0000);
    chk("R2 fixed", out_data, 32'h7FFF0000);
    chk("R3 flags", status & 32'h0300_300F, 32'h0300_100D);
  endtask

  task automatic t_after_sat;
    apply("R4", 32'h0005_FFFF);
    chk("R4 sticky kept", status & 32'h0300_0008, 32'h0200_0000);
  endtask

  task automatic t_both_min;
    apply("R2", 32'h8000_8000);
    chk("R2 both", out_data, 32'h7FFF7FFF);
    chk("R7 none", status & 32'h0000_3007, 32'h0);
  endtask

  task automatic t_lo_min;
    apply("R5", 32'h0000_8000);
    chk("R5 carry hi", {31'b0, status[13]}, 32'd1);
    chk("R6 carry lo clear", {30'b0, status[12], status[2]}, 32'd0);
  endtask

  task automatic t_zero;
    apply("R6", 32'h0000_0000);
    chk("R6 carry lo", {30'b0, status[12], status[2]}, 32'd3);
    chk("R7 zero", {31'b0, status[0]}, 32'd1);
  endtask

  task automatic t_idle;
    logic [31:0] s0;
    s0 = status;
    repeat (4) @(posedge clk);
    #1;
    chk("R10 idle status", status, s0);
    chk("R10 idle valid", {31'b0, out_valid}, 32'd0);
    chk("R8 untouched", status & 32'hFCFF_CFF0, 32'h0);
  endtask

  task automatic t_stall;
    logic [31:0] d0, s0;
    @(negedge clk);
    out_ready = 1'b0;
    apply("R10", 32'h0001_0002);
    d0 = out_data;
    s0 = status;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 32'h8000_8000;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      #1;
      chk("R11 not ready", {31'b0, in_ready}, 32'd0);
      chk("R11 data held", out_data, d0);
      chk("R11 status held", status, s0);
    end
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    exp_stat = model_stat(exp_stat, 32'h8000_8000);
    chk("R11 taken after stall", out_data, 32'h7FFF7FFF);
    chk("R11 status after stall", status, exp_stat);
  endtask

  initial begin
    #1;
    t_reset;
    #10;
    @(negedge clk);
    rst_n = 1'b1;
    t_plain;
    t_hi_min;
    t_after_sat;
    t_both_min;
    t_lo_min;
    t_zero;
    t_idle;
    t_stall;
    t_idle;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule